// File: doc/BRIEF.md
# Fixed-Priority Interrupt Resolver with Selective Masking

This block arbitrates between eight interrupt request channels in the manner of a classic programmable interrupt controller. Incoming requests are latched into a pending register. A mask register can disable each channel, and an in-service register records the channels whose handlers have been acknowledged but not yet closed. Channel 0 always has the highest priority and channel 7 the lowest. One channel is the cascade input, and it carries the interrupt line of a downstream slave controller.

The host loads the mask with a single write strobe. It switches the blocking rule with a mode strobe, acknowledges the interrupt output with a one-cycle strobe, and closes handlers with a non-specific end-of-interrupt strobe. In the normal rule, an open handler holds off its own channel and every channel below it. In the selective (special) mask rule, open handlers hold off only their own channel. The mask alone then decides what may interrupt. This lets a handler open up lower-priority sources while it runs.

Top module: `irq_res_top`

## Requirements
- R1: While reset is asserted, and on the cycles after it is released, `int_out` is 0 and `vec_idx` is 0. The pending, in-service and mask registers are all clear, and the normal rule is active.
- R2: A `mask_wr` strobe loads `mask_data` into the mask register as a whole. A bit value of 1 disables that channel. A masked channel never raises `int_out` and is never granted. Its latched request is granted once the bit is cleared.
- R3: A high level on a request input is latched into the pending register at the next clock edge, and it stays latched until that channel is acknowledged. `int_out` is 1 whenever some unmasked pending channel passes the active blocking rule. The lowest-numbered such channel is the winner.
- R4: The cascade channel (index `CASC_CH`, default 2) takes its request from `slave_int`. `req_in[CASC_CH]` has no effect. Setting mask bit `CASC_CH` silences every request from the slave.
- R5: An `ack` strobe while `int_out` is 1 has three effects from the next cycle on: `vec_idx` holds the binary index of the winner, the winner's pending bit is cleared, and its in-service bit is set. An `ack` while `int_out` is 0 changes no state.
- R6: Under the normal rule, an in-service bit at channel k blocks channels k through 7. A request on a channel below k still raises `int_out`.
- R7: A `mode_wr` strobe with `mode_set_en`=1 and `mode_special`=1 selects the selective mask rule. Under this rule an in-service bit blocks only its own channel, so a lower-priority unmasked channel may be granted.
- R8: An `eoi` strobe under the normal rule clears the lowest-numbered set in-service bit. Under the selective rule it clears the lowest-numbered set in-service bit whose mask bit is 0.
- R9: A `mode_wr` strobe with `mode_set_en`=1 and `mode_special`=0 restores the normal rule. A `mode_wr` strobe with `mode_set_en`=0 leaves the rule unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_in | input | NCH | Level-high request inputs; the bit at CASC_CH is unused |
| slave_int | input | 1 | Interrupt line from the cascaded slave controller |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_data | input | NCH | Mask value; 1 disables a channel |
| mode_wr | input | 1 | Mode command strobe |
| mode_set_en | input | 1 | Mode command: 1 lets the command change the rule |
| mode_special | input | 1 | Mode command: 1 selects the selective mask rule, 0 the normal rule |
| ack | input | 1 | Interrupt acknowledge strobe |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| int_out | output | 1 | Interrupt request towards the host |
| vec_idx | output | IDX_W | Index of the last acknowledged channel |

## Verification
The bench builds the block with its defaults: eight channels, with the cascade on channel 2. This makes the cascade's two effects visible next to ordinary channels on both sides of it. The unused input bit at that position is exercised, and so is the mask that silences the slave. With eight levels, nested handlers three deep can be built. This shows the normal rule blocking a channel below an open handler. It also shows the selective rule granting channel 7 while channel 6 is still open, and an end-of-interrupt skipping a masked open handler.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_SPECIAL = 1'b1
  } mask_mode_e;

endpackage

// File: rtl/irq_res_rst_sync.sv
module irq_res_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_n_sync = stg2_q;
endmodule

// File: rtl/irq_res_pick.sv
module irq_res_pick #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  cand,
  output logic [W-1:0]  gnt_oh,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    gnt_oh  = '0;
    gnt_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (cand[i]) begin
        gnt_oh    = '0;
        gnt_oh[i] = 1'b1;
        gnt_idx   = IW'(i);
      end
    end
  end

  assign gnt_any = |cand;
endmodule

// File: rtl/irq_res_req.sv
module irq_res_req #(
  parameter int unsigned NCH     = 8,
  parameter int unsigned CASC_CH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_in,
  input  logic           slave_int,
  input  logic [NCH-1:0] clr_oh,
  output logic [NCH-1:0] irr_q
);
  logic [NCH-1:0] src;
  logic [NCH-1:0] irr_d;

  for (genvar g = 0; g < NCH; g++) begin : g_src
    if (g == CASC_CH) begin : g_casc
      assign src[g] = slave_int;
    end else begin : g_dir
      assign src[g] = req_in[g];
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      irr_d[i] = clr_oh[i] ? 1'b0 : (irr_q[i] | src[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irr_q <= '0;
    else        irr_q <= irr_d;
  end
endmodule

// File: rtl/irq_res_svc.sv
module irq_res_svc #(
  parameter int unsigned NCH = 8,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_oh,
  input  logic           eoi,
  input  logic           special,
  input  logic [NCH-1:0] imr,
  output logic [NCH-1:0] isr_q
);
  logic [NCH-1:0] eoi_cand;
  logic [NCH-1:0] eoi_oh;
  logic [IW-1:0]  eoi_idx;
  logic           eoi_any;
  logic [NCH-1:0] isr_d;
  logic           isr_en;

  assign eoi_cand = special ? (isr_q & ~imr) : isr_q;

  irq_res_pick #(.W(NCH)) u_eoi_pick (
    .cand    (eoi_cand),
    .gnt_oh  (eoi_oh),
    .gnt_idx (eoi_idx),
    .gnt_any (eoi_any)
  );

  assign isr_en = eoi | (|set_oh);

  always_comb begin
    isr_d = isr_q;
    if (eoi && eoi_any) isr_d = isr_d & ~eoi_oh;
    isr_d = isr_d | set_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (isr_en) isr_q <= isr_d;
  end

  logic unused_idx;
  assign unused_idx = ^eoi_idx;
endmodule

// File: rtl/irq_res_top.sv
module irq_res_top #(
  parameter int unsigned NCH     = 8,
  parameter int unsigned CASC_CH = 2,
  localparam int unsigned IDX_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req_in,
  input  logic             slave_int,
  input  logic             mask_wr,
  input  logic [NCH-1:0]   mask_data,
  input  logic             mode_wr,
  input  logic             mode_set_en,
  input  logic             mode_special,
  input  logic             ack,
  input  logic             eoi,
  output logic             int_out,
  output logic [IDX_W-1:0] vec_idx
);
  import irq_res_pkg::*;

  logic             rst_n_sync;
  logic [NCH-1:0]   irr_q, isr_q, imr_q, imr_d;
  mask_mode_e       mode_q, mode_d;
  logic             smm_on;
  logic [NCH-1:0]   pend, blk, elig;
  logic [NCH-1:0]   win_oh;
  logic [IDX_W-1:0] win_idx;
  logic             win_any;
  logic             ack_go;
  logic [NCH-1:0]   grant_oh;
  logic [IDX_W-1:0] vec_q, vec_d;

  irq_res_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_res_req #(.NCH(NCH), .CASC_CH(CASC_CH)) u_req (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .req_in    (req_in),
    .slave_int (slave_int),
    .clr_oh    (grant_oh),
    .irr_q     (irr_q)
  );

  assign smm_on = (mode_q == MODE_SPECIAL);

  irq_res_svc #(.NCH(NCH)) u_svc (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .set_oh  (grant_oh),
    .eoi     (eoi),
    .special (smm_on),
    .imr     (imr_q),
    .isr_q   (isr_q)
  );

  // prefix OR: blk[i] set when any channel at or above priority i is in service
  assign blk[0] = isr_q[0];
  for (genvar g = 1; g < NCH; g++) begin : g_blk
    assign blk[g] = blk[g-1] | isr_q[g];
  end

  assign pend = irr_q & ~imr_q;
  assign elig = smm_on ? (pend & ~isr_q) : (pend & ~blk);

  irq_res_pick #(.W(NCH)) u_win_pick (
    .cand    (elig),
    .gnt_oh  (win_oh),
    .gnt_idx (win_idx),
    .gnt_any (win_any)
  );

  assign ack_go   = ack & win_any;
  assign grant_oh = ack_go ? win_oh : '0;

  // next-state
  always_comb begin
    imr_d  = mask_wr ? mask_data : imr_q;
    mode_d = (mode_wr && mode_set_en) ? mask_mode_e'(mode_special) : mode_q;
    vec_d  = ack_go ? win_idx : vec_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      imr_q  <= '0;
      mode_q <= MODE_NORMAL;
      vec_q  <= '0;
    end else begin
      if (mask_wr)               imr_q  <= imr_d;
      if (mode_wr && mode_set_en) mode_q <= mode_d;
      if (ack_go)                vec_q  <= vec_d;
    end
  end

  assign int_out = win_any;
  assign vec_idx = vec_q;
endmodule

// File: rtl/irq_res_chk.sv
module irq_res_chk #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             eoi,
  input logic             mode_wr,
  input logic             mode_set_en,
  input logic             int_out,
  input logic [NCH-1:0]   irr,
  input logic [NCH-1:0]   isr,
  input logic [NCH-1:0]   imr,
  input logic             smm,
  input logic [IDX_W-1:0] win_idx,
  input logic [IDX_W-1:0] vec_idx
);
  logic hi_isr;
  logic eoi_has;

  always_comb begin
    hi_isr  = 1'b0;
    eoi_has = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (i <= int'(win_idx) && isr[i]) hi_isr = 1'b1;
      if (isr[i] && (!smm || !imr[i])) eoi_has = 1'b1;
    end
  end

  assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> !imr[win_idx]);

  assert_ack_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out) |=> (isr[$past(win_idx)] && !irr[$past(win_idx)] && vec_idx == $past(win_idx)));

  assert_isr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !eoi) |=> isr == $past(isr));

  assert_normal_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && !smm) |-> !hi_isr);

  assert_no_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> !isr[win_idx]);

  assert_eoi_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && eoi_has) |=> ($countones(isr) + 1 == $past($countones(isr))));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_wr && mode_set_en) |=> smm == $past(smm));
endmodule

bind irq_res_top irq_res_chk #(.NCH(NCH), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .ack         (ack),
  .eoi         (eoi),
  .mode_wr     (mode_wr),
  .mode_set_en (mode_set_en),
  .int_out     (int_out),
  .irr         (irr_q),
  .isr         (isr_q),
  .imr         (imr_q),
  .smm         (smm_on),
  .win_idx     (win_idx),
  .vec_idx     (vec_idx)
);

// File: tb/test_irq_res_top.sv
module test_irq_res_top;
  localparam int NCH = 8;
  localparam int IW  = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] req_in;
  logic           slave_int;
  logic           mask_wr;
  logic [NCH-1:0] mask_data;
  logic           mode_wr, mode_set_en, mode_special;
  logic           ack, eoi;
  logic           int_out;
  logic [IW-1:0]  vec_idx;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  irq_res_top i_irq_res_top (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .slave_int(slave_int),
    .mask_wr(mask_wr), .mask_data(mask_data), .mode_wr(mode_wr),
    .mode_set_en(mode_set_en), .mode_special(mode_special),
    .ack(ack), .eoi(eoi), .int_out(int_out), .vec_idx(vec_idx)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_req(logic [NCH-1:0] v, logic sl);
    req_in = v; slave_int = sl;
    @(negedge clk);
    req_in = '0; slave_int = 1'b0;
  endtask

  task automatic set_mask(logic [NCH-1:0] v);
    mask_wr = 1'b1; mask_data = v;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic set_mode(logic en, logic sp);
    mode_wr = 1'b1; mode_set_en = en; mode_special = sp;
    @(negedge clk);
    mode_wr = 1'b0; mode_set_en = 1'b0; mode_special = 1'b0;
  endtask

  // driver: expected vector goes to scoreboard before the strobe
  task automatic ack_exp(int ch);
    exp_q.push_back(ch);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  // monitor: an ack seen at an edge is compared at the following negedge
  initial begin
    forever begin
      bit seen;
      @(posedge clk);
      seen = ack;
      @(negedge clk);
      if (seen && exp_q.size() > 0) check("R5 vector", int'(vec_idx), exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_in = '0; slave_int = 1'b0; mask_wr = 1'b0; mask_data = '0;
    mode_wr = 1'b0; mode_set_en = 1'b0; mode_special = 1'b0; ack = 1'b0; eoi = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 int_out in reset", int'(int_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 int_out", int'(int_out), 0);
    check("R1 vec_idx", int'(vec_idx), 0);

    // R3 / R6: channels 3 and 5, lower index wins, open handler blocks below
    pulse_req(8'h28, 1'b0);
    check("R3 int raised", int'(int_out), 1);
    ack_exp(3);
    check("R6 ch5 blocked by ch3", int'(int_out), 0);
    pulse_req(8'h02, 1'b0);
    check("R6 ch1 above open ch3", int'(int_out), 1);
    ack_exp(1);
    check("R6 all blocked", int'(int_out), 0);

    // R8 normal: first eoi closes ch1, second closes ch3
    do_eoi();
    check("R8 ch3 still open", int'(int_out), 0);
    do_eoi();
    check("R8 ch3 closed", int'(int_out), 1);
    ack_exp(5);
    do_eoi();
    check("R8 idle", int'(int_out), 0);

    // R2 mask
    set_mask(8'h10);
    pulse_req(8'h10, 1'b0);
    check("R2 masked ch4", int'(int_out), 0);
    set_mask(8'h00);
    check("R2 unmasked ch4", int'(int_out), 1);
    ack_exp(4);
    do_eoi();

    // R4 cascade
    pulse_req(8'h04, 1'b0);
    check("R4 req_in at cascade ignored", int'(int_out), 0);
    set_mask(8'h04);
    pulse_req(8'h00, 1'b1);
    check("R4 slave silenced", int'(int_out), 0);
    set_mask(8'h00);
    check("R4 slave after unmask", int'(int_out), 1);
    ack_exp(2);
    do_eoi();
    check("R4 idle", int'(int_out), 0);

    // R5 ack without interrupt
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R5 idle ack vec", int'(vec_idx), 2);
    check("R5 idle ack int", int'(int_out), 0);

    // R7 selective mask rule
    set_mode(1'b1, 1'b1);
    pulse_req(8'h40, 1'b0);
    ack_exp(6);
    pulse_req(8'h80, 1'b0);
    check("R7 ch7 despite open ch6", int'(int_out), 1);
    ack_exp(7);

    // R9 no-change command, R8 selective eoi skips masked ch6
    set_mode(1'b0, 1'b0);
    set_mask(8'h40);
    do_eoi();
    set_mask(8'h00);
    pulse_req(8'h80, 1'b0);
    check("R8 selective eoi closed ch7 (R9 rule kept)", int'(int_out), 1);
    ack_exp(7);

    // R9 back to normal rule
    set_mode(1'b1, 1'b0);
    do_eoi();
    do_eoi();
    pulse_req(8'h08, 1'b0);
    ack_exp(3);
    pulse_req(8'h10, 1'b0);
    check("R9 normal blocking restored", int'(int_out), 0);
    do_eoi();
    check("R9 ch4 after eoi", int'(int_out), 1);
    ack_exp(4);
    do_eoi();
    @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule